// File: doc/BRIEF.md
# Synchronous Serial Master Port with Paired FIFOs

This block is a synchronous serial master that a processor drives through a small 16-bit register bus. Software writes words into the data register. Each word goes into an eight-entry transmit queue. When the port is enabled, a shift engine takes words from that queue one at a time. It sends each one on the serial data output, MSB first, while a serial clock toggles and an active-low select is held. At the same moments it samples the serial data input. For every frame sent, it places exactly one word in an eight-entry receive queue, which software drains by reading the data register.

Clock polarity, clock phase, frame length (1 to 16 bits) and the bit rate can all be programmed. The bit rate is set by two factors: an even prescale value and a rate multiplier in the main control register. A status register reports the fill state of both queues and whether the engine still has work. Four read-only identification bytes let software recognise the block.

Top module: `sport_top`

## Requirements
- R1: Control word A (offset 0x000) is a full 16-bit read/write register. In control word B (offset 0x004), only bit 1 (enable) is stored, and the other bits read 0. The prescale register (offset 0x010) stores bits 7:1, and bit 0 always reads 0. Any unmapped offset reads 0. All registers reset to 0.
- R2: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC read 0x0022, 0x0010, 0x0004 and 0x0000.
- R3: The status register (offset 0x00C) reads bit 0 = TX queue empty, bit 1 = TX queue not full, bit 2 = RX queue not empty, bit 3 = RX queue full, bit 4 = busy, and 0 in all other bits. Busy is 1 while a frame is in progress, or while the port is enabled and the TX queue holds a word. After reset the status reads 0x0003.
- R4: A write to the data register (offset 0x008) appends the word to an 8-entry TX queue. A write that finds the queue full is dropped.
- R5: A read of the data register returns the oldest RX word and removes it. A read of an empty RX queue returns 0 and changes nothing. A frame that completes while the RX queue is full is discarded.
- R6: While the enable bit is 0, no frame starts, the select output stays high and queued TX words stay queued.
- R7: Bits 3:0 of control word A give the frame length minus one. Received words are right-justified, and their upper bits are 0.
- R8: Each frame is sent MSB first.
- R9: One half period of the serial clock lasts max(prescale[7:1],1) × (A[15:8]+1) system clocks. A frame holds the select low for exactly 2·N half periods, where N is the frame length. Between frames the select is high for at least one cycle. While the select is high, the serial clock rests at the polarity bit A[6].
- R10: With phase bit A[7] = 0, the input is sampled on each leading clock edge and the output changes on trailing edges. With A[7] = 1, the output changes on every leading edge after the first, and the input is sampled on trailing edges.
- R11: The full and empty decisions use queue occupancy at the start of a cycle. A push and a pop in the same cycle both take effect, except that a push into a queue that was full is dropped even if a pop also happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the RX queue at the data offset) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low frame select |

## Verification
Two pairs of actions can fall in the same cycle: a bus write to a full TX queue while the engine takes a word from it, and a bus read of a full RX queue while a frame completes and pushes into it. The bench provokes the first by writing on every cycle against slow frames. It provokes the second by letting the RX queue fill and then issuing a combined write-and-read every cycle against short frames. Its behavioural model, which applies the start-of-cycle occupancy rule, judges the status word, the returned data, and the select and clock levels on every cycle.

// File: rtl/sport_pkg.sv
package sport_pkg;
   localparam int ADDR_W = 12;

   localparam logic [ADDR_W-1:0] A_CTRLA = 12'h000;
   localparam logic [ADDR_W-1:0] A_CTRLB = 12'h004;
   localparam logic [ADDR_W-1:0] A_DATA  = 12'h008;
   localparam logic [ADDR_W-1:0] A_STAT  = 12'h00C;
   localparam logic [ADDR_W-1:0] A_PRESC = 12'h010;
   localparam logic [ADDR_W-1:0] A_ID0   = 12'hFE0;
   localparam logic [ADDR_W-1:0] A_ID1   = 12'hFE4;
   localparam logic [ADDR_W-1:0] A_ID2   = 12'hFE8;
   localparam logic [ADDR_W-1:0] A_ID3   = 12'hFEC;

   localparam logic [7:0] ID_B0 = 8'h22;
   localparam logic [7:0] ID_B1 = 8'h10;
   localparam logic [7:0] ID_B2 = 8'h04;
   localparam logic [7:0] ID_B3 = 8'h00;

   // status bit positions
   localparam int S_TXE  = 0;
   localparam int S_TXNF = 1;
   localparam int S_RXNE = 2;
   localparam int S_RXF  = 3;
   localparam int S_BSY  = 4;

   // control word A / B fields
   localparam int CA_POL  = 6;
   localparam int CA_PHA  = 7;
   localparam int CA_RATE = 8;
   localparam int CB_EN   = 1;

   typedef enum logic {SH_IDLE, SH_RUN} sh_state_t;
endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic                       pop,
   input  logic [W-1:0]               din,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       empty
);
   localparam int CW = $clog2(DEPTH+1);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign count   = cnt;
   assign dout    = mem[rp];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/sport_baud.sv
module sport_baud #(
   parameter int PRESC_W = 8,
   parameter int RATE_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               run,
   input  logic [PRESC_W-2:0] presc_hi,
   input  logic [RATE_W-1:0]  rate,
   output logic               tick
);
   localparam int HALF_W = (PRESC_W - 1) + (RATE_W + 1);

   logic [PRESC_W-2:0] pdiv;
   logic [RATE_W:0]    rate_p1;
   logic [HALF_W-1:0]  half, hcnt;

   assign pdiv    = (presc_hi == '0) ? PRESC_W'(1) : presc_hi;
   assign rate_p1 = {1'b0, rate} + 1'b1;
   assign half    = HALF_W'(pdiv) * HALF_W'(rate_p1);
   assign tick    = run && (hcnt == half - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hcnt <= '0;
      else if (restart) hcnt <= '0;
      else if (run)     hcnt <= tick ? '0 : hcnt + 1'b1;
   end
endmodule

// File: rtl/sport_shifter.sv
module sport_shifter
   import sport_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en,
   input  logic                        cpol,
   input  logic                        cpha,
   input  logic [$clog2(DATA_W)-1:0]   size_m1,
   input  logic                        tx_avail,
   input  logic [DATA_W-1:0]           tx_word,
   input  logic                        tick,
   input  logic                        miso,
   output logic                        start,
   output logic                        rx_push,
   output logic [DATA_W-1:0]           rx_word,
   output logic                        sclk,
   output logic                        mosi,
   output logic                        ss_n,
   output logic                        running
);
   localparam int SIZE_W = $clog2(DATA_W);

   sh_state_t           st;
   logic [SIZE_W:0]     ecnt;
   logic [SIZE_W-1:0]   n_m1, lalign;
   logic [DATA_W-1:0]   tx_sh, rx_sh, rx_nx;
   logic                phase, edge_go, lead, do_smp, do_shf, last;

   assign running = (st == SH_RUN);
   assign start   = !running && en && tx_avail;
   assign edge_go = running && tick;
   assign lead    = ~ecnt[0];
   assign do_smp  = cpha ? ~lead : lead;
   assign do_shf  = cpha ? (lead && (ecnt != '0)) : ~lead;
   assign last    = (ecnt == {n_m1, 1'b1});
   assign rx_nx   = {rx_sh[DATA_W-2:0], miso};
   assign rx_word = do_smp ? rx_nx : rx_sh;
   assign rx_push = edge_go && last;
   assign lalign  = SIZE_W'(DATA_W - 1) - size_m1;

   assign sclk = cpol ^ phase;
   assign mosi = tx_sh[DATA_W-1];
   assign ss_n = !(running && en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SH_IDLE;
         ecnt  <= '0;
         phase <= 1'b0;
         n_m1  <= '0;
         tx_sh <= '0;
         rx_sh <= '0;
      end else if (start) begin
         st    <= SH_RUN;
         ecnt  <= '0;
         phase <= 1'b0;
         n_m1  <= size_m1;
         tx_sh <= tx_word << lalign;
         rx_sh <= '0;
      end else if (edge_go) begin
         phase <= ~phase;
         ecnt  <= ecnt + 1'b1;
         if (do_smp) rx_sh <= rx_nx;
         if (do_shf) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
         if (last)   st    <= SH_IDLE;
      end
   end
endmodule

// File: rtl/sport_top.sv
module sport_top
   import sport_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int FIFO_DEPTH = 8,
   parameter int PRESC_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [11:0]       bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              ss_n
);
   localparam int SIZE_W = $clog2(DATA_W);
   localparam int RATE_W = DATA_W - CA_RATE;
   localparam int CW     = $clog2(FIFO_DEPTH + 1);

   generate
      if (DATA_W != 16) begin : g_bad_width
         $error("sport_top: register bus is 16 bits, DATA_W must be 16");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("sport_top: FIFO_DEPTH must be at least 2");
      end
      if (PRESC_W < 2 || PRESC_W > DATA_W) begin : g_bad_presc
         $error("sport_top: PRESC_W must lie in 2..DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0]  ctrla_q;
   logic               en_q;
   logic [PRESC_W-1:1] presc_q;

   logic               tx_push_req, rx_pop_req;
   logic [DATA_W-1:0]  tx_dout, rx_dout, rx_word;
   logic [CW-1:0]      tx_cnt, rx_cnt;
   logic               tx_full, tx_empty, rx_full, rx_empty;
   logic               start, rx_push, running, tick, busy;
   logic [DATA_W-1:0]  status;

   assign tx_push_req = bus_wr && (bus_addr == A_DATA);
   assign rx_pop_req  = bus_rd && (bus_addr == A_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrla_q <= '0;
         en_q    <= 1'b0;
         presc_q <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            A_CTRLA: ctrla_q <= bus_wdata;
            A_CTRLB: en_q    <= bus_wdata[CB_EN];
            A_PRESC: presc_q <= bus_wdata[PRESC_W-1:1];
            default: ;
         endcase
      end
   end

   sport_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push_req), .pop(start),
      .din(bus_wdata), .dout(tx_dout), .count(tx_cnt),
      .full(tx_full), .empty(tx_empty)
   );

   sport_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop_req),
      .din(rx_word), .dout(rx_dout), .count(rx_cnt),
      .full(rx_full), .empty(rx_empty)
   );

   sport_baud #(.PRESC_W(PRESC_W), .RATE_W(RATE_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .restart(start), .run(running && en_q),
      .presc_hi(presc_q), .rate(ctrla_q[DATA_W-1:CA_RATE]), .tick(tick)
   );

   sport_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(en_q),
      .cpol(ctrla_q[CA_POL]), .cpha(ctrla_q[CA_PHA]),
      .size_m1(ctrla_q[SIZE_W-1:0]), .tx_avail(!tx_empty), .tx_word(tx_dout),
      .tick(tick), .miso(miso), .start(start), .rx_push(rx_push),
      .rx_word(rx_word), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
      .running(running)
   );

   assign busy = running || (en_q && !tx_empty);

   always_comb begin
      status         = '0;
      status[S_TXE]  = tx_empty;
      status[S_TXNF] = !tx_full;
      status[S_RXNE] = !rx_empty;
      status[S_RXF]  = rx_full;
      status[S_BSY]  = busy;
   end

   always_comb begin
      case (bus_addr)
         A_CTRLA: bus_rdata = ctrla_q;
         A_CTRLB: bus_rdata = DATA_W'({en_q, 1'b0});
         A_DATA:  bus_rdata = rx_empty ? '0 : rx_dout;
         A_STAT:  bus_rdata = status;
         A_PRESC: bus_rdata = DATA_W'({presc_q, 1'b0});
         A_ID0:   bus_rdata = DATA_W'(ID_B0);
         A_ID1:   bus_rdata = DATA_W'(ID_B1);
         A_ID2:   bus_rdata = DATA_W'(ID_B2);
         A_ID3:   bus_rdata = DATA_W'(ID_B3);
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sport_checks.sv
module sport_checks #(
   parameter int DEPTH = 8,
   parameter int CW    = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ss_n,
   input logic          sclk,
   input logic          cpol,
   input logic          en,
   input logic          busy,
   input logic [CW-1:0] tx_cnt,
   input logic [CW-1:0] rx_cnt,
   input logic          tx_push_req,
   input logic          tx_pop,
   input logic          rx_push,
   input logic          rx_pop_req,
   input logic [15:0]   bus_rdata
);
   p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ss_n |-> (sclk == cpol));

   p_quiet_sclk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_n && $past(ss_n) && $stable(cpol)) |-> $stable(sclk));

   p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && ss_n) |=> ss_n);

   p_busy_ss_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ss_n);

   p_tx_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_cnt == CW'(DEPTH)) && tx_push_req && !tx_pop) |=> $stable(tx_cnt));

   p_rx_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_cnt == CW'(DEPTH)) && rx_push && !rx_pop_req) |=> $stable(rx_cnt));

   p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop_req && (rx_cnt == '0)) |-> (bus_rdata == 16'h0000));
endmodule

bind sport_top sport_checks #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sclk(sclk),
   .cpol(ctrla_q[sport_pkg::CA_POL]), .en(en_q), .busy(busy),
   .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_push_req(tx_push_req),
   .tx_pop(start), .rx_push(rx_push), .rx_pop_req(rx_pop_req),
   .bus_rdata(bus_rdata)
);

// File: tb/sim_sport_top.sv
module sim_sport_top;
   import sport_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr;
   logic        bus_wr, bus_rd;
   logic [15:0] bus_wdata, bus_rdata;
   logic        sclk, mosi, miso, ss_n;
   logic        inv;

   always #4 clk = ~clk;   // 125 MHz
   assign miso = mosi ^ inv;

   sport_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
   );

   int    n_cmp = 0, n_bad = 0, wd = 0;
   string phase = "reset";

   task automatic chk(input int act, input int exp, input string tag);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s [%s]: actual 0x%0h expected 0x%0h", tag, phase, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // ---------------- behavioural reference model ----------------
   int          txq[$], rxq[$];
   logic [15:0] m_ca;
   logic        m_en;
   logic [7:0]  m_ps;
   bit          m_act, m_inv;
   int          m_cyc, m_n, m_half, m_cur;
   int          last_tx, last_n;
   bit          s_en, s_start, s_fin;
   int          s_txn, s_rxn, s_p;

   always @(posedge clk) begin
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         m_ca = '0; m_en = 1'b0; m_ps = '0; m_act = 0; m_cyc = 0;
         m_n = 1; m_half = 1; last_tx = 0; last_n = 0;
      end else begin
         s_en  = m_en;
         s_txn = txq.size();
         s_rxn = rxq.size();
         s_start = !m_act && s_en && (s_txn > 0);
         s_fin = 0;
         if (m_act && s_en) begin
            m_cyc++;
            if (m_cyc == 2 * m_n * m_half) begin s_fin = 1; m_act = 0; end
         end
         if (s_fin && s_rxn < 8)
            rxq.push_back(((m_inv ? ~m_cur : m_cur) & ((1 << m_n) - 1)) & 16'hFFFF);
         if (bus_rd && bus_addr == A_DATA && s_rxn > 0) void'(rxq.pop_front());
         if (s_start) begin
            m_cur = txq.pop_front();
            m_act = 1; m_cyc = 0; m_inv = inv;
            m_n = int'(m_ca[3:0]) + 1;
            s_p = int'(m_ps[7:1]); if (s_p == 0) s_p = 1;
            m_half = s_p * (int'(m_ca[15:8]) + 1);
            last_tx = m_cur & ((1 << m_n) - 1); last_n = m_n;
         end
         if (bus_wr && bus_addr == A_DATA && s_txn < 8) txq.push_back(int'(bus_wdata));
         if (bus_wr && bus_addr == A_CTRLA) m_ca = bus_wdata;
         if (bus_wr && bus_addr == A_CTRLB) m_en = bus_wdata[1];
         if (bus_wr && bus_addr == A_PRESC) m_ps = bus_wdata[7:0] & 8'hFE;
      end
   end

   function automatic int mstat();
      int s = 0;
      if (txq.size() == 0) s |= 1;
      if (txq.size() < 8)  s |= 2;
      if (rxq.size() > 0)  s |= 4;
      if (rxq.size() == 8) s |= 8;
      if (m_act || (m_en && txq.size() > 0)) s |= 16;
      return s;
   endfunction

   // ---------------- per-cycle comparison ----------------
   logic prv_sclk = 1'b0, prv_ss = 1'b1, lead, samp;
   int   cap = 0, ncap = 0, e_sclk, e_rd;

   always @(negedge clk) begin
      if (rst_n) begin
         chk(ss_n, !(m_act && m_en), "R9 R6 select level");
         e_sclk = m_ca[6] ^ (m_act ? ((m_cyc / m_half) % 2) : 0);
         chk(sclk, e_sclk, "R9 serial clock");
         if (bus_addr == A_STAT) chk(bus_rdata, mstat(), "R3 R11 status");
         if (bus_rd && bus_addr == A_DATA) begin
            e_rd = (rxq.size() > 0) ? rxq[0] : 0;
            chk(bus_rdata, e_rd, "R5 R7 data read");
         end
         if (!ss_n && prv_ss) begin cap = 0; ncap = 0; end
         if (!prv_ss && sclk !== prv_sclk) begin
            lead = (sclk != m_ca[6]);
            samp = m_ca[7] ? !lead : lead;
            if (samp) begin cap = ((cap << 1) | int'(mosi)) & 16'hFFFF; ncap++; end
         end
         if (ss_n && !prv_ss) begin
            chk(ncap, last_n, "R7 bits per frame");
            chk(cap, last_tx, "R8 R10 output bit order");
         end
      end
      prv_sclk = sclk;
      prv_ss   = ss_n;
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected < 150000", wd);
         report();
      end
   end

   // ---------------- stimulus ----------------
   task automatic idle_bus();
      bus_addr = A_STAT; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
   endtask
   task automatic cyc();
      @(posedge clk); #1;
   endtask
   task automatic wr(input logic [11:0] a, input logic [15:0] d);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d; cyc(); idle_bus();
   endtask
   task automatic rd_chk(input logic [11:0] a, input int exp, input string tag);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk); chk(bus_rdata, exp, tag);
      cyc(); idle_bus();
   endtask
   task automatic rd_data();
      bus_addr = A_DATA; bus_rd = 1'b1; cyc(); idle_bus();
   endtask
   task automatic wr_rd(input logic [15:0] d);
      bus_addr = A_DATA; bus_wr = 1'b1; bus_rd = 1'b1; bus_wdata = d; cyc(); idle_bus();
   endtask
   task automatic wait_idle();
      while (m_act || (m_en && txq.size() > 0)) cyc();
      cyc();
   endtask

   int sizes[4] = '{16, 4, 1, 11};
   int rates[4] = '{0, 2, 1, 0};
   int pscs[4]  = '{2, 4, 0, 6};

   initial begin
      idle_bus(); inv = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      rd_chk(A_STAT, 16'h0003, "R3 reset status");
      rd_chk(A_CTRLA, 0, "R1 reset control A");

      phase = "R1 registers";
      wr(A_CTRLA, 16'hA5C3); rd_chk(A_CTRLA, 16'hA5C3, "R1 control A");
      wr(A_CTRLB, 16'hFFFD); rd_chk(A_CTRLB, 16'h0000, "R1 control B");
      wr(A_CTRLB, 16'hFFFF); rd_chk(A_CTRLB, 16'h0002, "R1 control B enable");
      wr(A_CTRLB, 16'h0000);
      wr(A_PRESC, 16'h0037); rd_chk(A_PRESC, 16'h0036, "R1 prescale even");
      rd_chk(12'h02C, 0, "R1 unmapped");
      rd_chk(12'h800, 0, "R1 unmapped high");

      phase = "R2 identification";
      rd_chk(A_ID0, 16'h0022, "R2 id0");
      rd_chk(A_ID1, 16'h0010, "R2 id1");
      rd_chk(A_ID2, 16'h0004, "R2 id2");
      rd_chk(A_ID3, 16'h0000, "R2 id3");

      phase = "R4 R6 fill while disabled";
      wr(A_CTRLA, 16'h0007); wr(A_PRESC, 16'h0002);
      for (int i = 0; i < 10; i++) wr(A_DATA, 16'h0100 + 16'(i * 37));
      repeat (20) cyc();
      rd_chk(A_STAT, 16'h0000, "R4 R6 full and held");

      phase = "R5 enable and fill RX";
      wr(A_CTRLB, 16'h0002);
      wait_idle();
      rd_chk(A_STAT, 16'h000F, "R5 RX full");
      wr(A_DATA, 16'h00EE); wr(A_DATA, 16'h00DD);
      wait_idle();
      for (int i = 0; i < 9; i++) rd_data();
      rd_chk(A_STAT, 16'h0003, "R5 drained");

      for (int m = 0; m < 4; m++) begin
         phase = $sformatf("R9 R10 mode %0d", m);
         inv = m[0];
         wr(A_CTRLA, 16'((rates[m] << 8) | (((m >> 1) & 1) << 7) | ((m & 1) << 6) | (sizes[m] - 1)));
         wr(A_PRESC, 16'(pscs[m]));
         wr(A_DATA, 16'hB5C3 ^ 16'(m * 16'h1111));
         wr(A_DATA, 16'h8001);
         wr(A_DATA, 16'h6A59);
         wait_idle();
         for (int i = 0; i < 3; i++) rd_data();
      end

      phase = "R11 TX collision";
      inv = 1'b0;
      wr(A_CTRLA, 16'h0000); wr(A_PRESC, 16'h0008);
      for (int i = 0; i < 24; i++) wr(A_DATA, 16'(i + 1));
      wait_idle();

      phase = "R11 RX collision";
      wr(A_PRESC, 16'h0002);
      for (int i = 0; i < 20; i++) wr_rd(16'(i ^ 5));
      wait_idle();
      for (int i = 0; i < 9; i++) rd_data();
      rd_chk(A_STAT, 16'h0003, "R11 final status");

      report();
   end
endmodule